// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block sequences the three array operations of a scaled NAND-style flash: page read, page program and block erase. The array lives inside the block as a register model. Each cell holds a data bit and a small count of the erase pulses it still needs. Delays are counted in clock cycles. A read takes the shortest time, a program takes longer, and one erase pulse takes longer still.

An erase is a closed loop. The sequencer waits out one erase pulse on the whole block. It then senses the block back one page per cycle across all pages. It repeats the pulse while any cell still reads 0. The loop stops when the block is clean, or when it has spent the maximum number of pulses; in that second case it raises a failure status. Programming merges the supplied page-wide data into one page, and a program can only clear bits.

A test hook marks chosen cells of a page as hard to erase. This lets the retry path and the failure path be exercised.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, done, erase_fail, erase_pulses and rd_data are all 0, and every cell of the array reads 1.
- R2: When the block is idle, a cycle with cmd_valid high and cmd_op equal to 1 (read), 2 (program) or 3 (erase) is accepted, and busy is high from the next cycle. cmd_op equal to 0 is ignored.
- R3: Commands presented while busy is high are ignored; they change neither the array nor the timing of the running operation.
- R4: A read keeps busy high for T_READ cycles after the acceptance edge. It then updates rd_data with the addressed page (cmd_blk selects the block, cmd_page the page within it).
- R5: A program keeps busy high for T_PROG cycles. It then leaves the addressed page equal to its old value AND cmd_wdata, so it only moves bits from 1 to 0. Other pages are unchanged.
- R6: One erase iteration takes T_ERASE + PAGES_PER_BLK cycles. That is the pulse wait, then one verify cycle per page of the block.
- R7: An erase acts on every page of the addressed block and on no other block. It repeats pulses until every cell of that block reads 1. erase_pulses reports the number of pulses used.
- R8: A hard_we cycle clears each cell of the addressed page selected by hard_mask to 0 and gives it a pulse need of hard_cnt. Such a cell reads 1 only after max(hard_cnt,1) erase pulses.
- R9: If the block is still not clean after MAX_ERASE_TRIES pulses, the erase ends with erase_fail set to 1 and erase_pulses equal to MAX_ERASE_TRIES. erase_fail holds until the next accepted command clears it. Cells keep their remaining pulse need.
- R10: The delay parameters must satisfy T_READ < T_PROG < T_ERASE; elaboration stops otherwise.
- R11: done is a single-cycle pulse in the first cycle with busy low after an operation, and it is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 read, 2 program, 3 erase |
| cmd_blk | input | BLK_W | Block address |
| cmd_page | input | PG_W | Page within the block |
| cmd_wdata | input | PAGE_BITS | Page data for a program |
| hard_we | input | 1 | Test hook: mark cells hard to erase |
| hard_blk | input | BLK_W | Block of the marked page |
| hard_page | input | PG_W | Page of the marked cells |
| hard_mask | input | PAGE_BITS | Cells to mark |
| hard_cnt | input | CNT_W | Erase pulses the marked cells need |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| erase_fail | output | 1 | Last erase ran out of pulses |
| erase_pulses | output | TRY_W | Pulses used by the last erase |
| rd_data | output | PAGE_BITS | Page returned by the last read |

## Verification
A read result is due T_READ cycles after the acceptance edge and a program T_PROG cycles after it. An erase needing k pulses ends k·(T_ERASE + PAGES_PER_BLK) cycles after acceptance. A failing erase ends after MAX_ERASE_TRIES such iterations. The bench drives inputs and samples outputs on falling edges. It counts the falling edges at which busy is high and compares that count with these formulas. It reads done, rd_data, erase_pulses and erase_fail at the first falling edge where busy is low, and checks that done is gone one edge later.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_PROG,
    ST_PULSE,
    ST_VERIFY
  } seq_state_e;

  // Linear page number inside the whole array.
  function automatic int flat_page(input int blk, input int page, input int pages_per_blk);
    return blk * pages_per_blk + page;
  endfunction

  // Cycles spent by one pulse-plus-verify round.
  function automatic int iter_cycles(input int t_erase, input int pages_per_blk);
    return t_erase + pages_per_blk;
  endfunction

endpackage

// File: rtl/flash_delay_timer.sv
module flash_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int PAGE_BITS     = 16,
  parameter int PAGES_PER_BLK = 64,
  parameter int NUM_BLKS      = 2,
  parameter int CNT_W         = 4,
  localparam int TOTAL_PAGES  = NUM_BLKS * PAGES_PER_BLK,
  localparam int IDX_W        = (TOTAL_PAGES > 1) ? $clog2(TOTAL_PAGES) : 1,
  localparam int BLK_W        = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ers_en,
  input  logic [BLK_W-1:0]     ers_blk,
  input  logic                 prg_en,
  input  logic [IDX_W-1:0]     prg_idx,
  input  logic [PAGE_BITS-1:0] prg_data,
  input  logic                 hard_we,
  input  logic [IDX_W-1:0]     hard_idx,
  input  logic [PAGE_BITS-1:0] hard_mask,
  input  logic [CNT_W-1:0]     hard_cnt,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [PAGE_BITS-1:0] rd_page
);
  logic [PAGE_BITS-1:0] bits_q [TOTAL_PAGES];
  logic [CNT_W-1:0]     wear_q [TOTAL_PAGES][PAGE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < TOTAL_PAGES; p++) begin
        bits_q[p] <= '1;
        for (int b = 0; b < PAGE_BITS; b++) wear_q[p][b] <= '0;
      end
    end else begin
      for (int p = 0; p < TOTAL_PAGES; p++) begin
        for (int b = 0; b < PAGE_BITS; b++) begin
          if (ers_en && (p / PAGES_PER_BLK) == int'(ers_blk)) begin
            if (wear_q[p][b] <= CNT_W'(1)) begin
              bits_q[p][b] <= 1'b1;
              wear_q[p][b] <= '0;
            end else begin
              wear_q[p][b] <= wear_q[p][b] - 1'b1;
            end
          end else if (prg_en && p == int'(prg_idx) && !prg_data[b]) begin
            bits_q[p][b] <= 1'b0;
          end
          if (hard_we && p == int'(hard_idx) && hard_mask[b]) begin
            bits_q[p][b] <= 1'b0;
            wear_q[p][b] <= hard_cnt;
          end
        end
      end
    end
  end

  assign rd_page = bits_q[rd_idx];
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BITS       = 16,
  parameter int PAGES_PER_BLK   = 64,
  parameter int NUM_BLKS        = 2,
  parameter int T_READ          = 4,
  parameter int T_PROG          = 10,
  parameter int T_ERASE         = 40,
  parameter int MAX_ERASE_TRIES = 8,
  localparam int TOTAL_PAGES    = NUM_BLKS * PAGES_PER_BLK,
  localparam int IDX_W          = (TOTAL_PAGES > 1) ? $clog2(TOTAL_PAGES) : 1,
  localparam int BLK_W          = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int PG_W           = (PAGES_PER_BLK > 1) ? $clog2(PAGES_PER_BLK) : 1,
  localparam int TRY_W          = $clog2(MAX_ERASE_TRIES + 1),
  localparam int TMR_W          = $clog2(T_ERASE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BLK_W-1:0]     cmd_blk,
  input  logic [PG_W-1:0]      cmd_page,
  input  logic [PAGE_BITS-1:0] cmd_wdata,
  input  logic                 tmr_zero,
  input  logic [PAGE_BITS-1:0] rd_page,
  output logic                 tmr_load,
  output logic [TMR_W-1:0]     tmr_val,
  output logic                 ers_en,
  output logic [BLK_W-1:0]     ers_blk,
  output logic                 prg_en,
  output logic [IDX_W-1:0]     prg_idx,
  output logic [PAGE_BITS-1:0] prg_data,
  output logic [IDX_W-1:0]     rd_idx,
  output logic                 accept,
  output logic                 in_verify,
  output logic                 busy,
  output logic                 done,
  output logic                 erase_fail,
  output logic [TRY_W-1:0]     erase_pulses,
  output logic [PAGE_BITS-1:0] rd_data
);
  seq_state_e           state_q;
  logic [BLK_W-1:0]     blk_q;
  logic [PG_W-1:0]      page_q;
  logic [PAGE_BITS-1:0] data_q;
  logic [PG_W-1:0]      scan_q;
  logic                 dirty_q;
  logic [TRY_W-1:0]     pulses_q;
  logic                 done_q;
  logic                 fail_q;
  logic [PAGE_BITS-1:0] rd_q;

  logic page_ok, scan_last, blk_clean, out_of_tries, retry;

  function automatic logic [TMR_W-1:0] wait_for(input logic [1:0] op);
    case (op)
      OP_READ: return TMR_W'(T_READ - 1);
      OP_PROG: return TMR_W'(T_PROG - 1);
      default: return TMR_W'(T_ERASE - 1);
    endcase
  endfunction

  assign accept       = (state_q == ST_IDLE) && cmd_valid && (cmd_op != OP_NOP);
  assign in_verify    = (state_q == ST_VERIFY);
  assign page_ok      = &rd_page;
  assign scan_last    = (scan_q == PG_W'(PAGES_PER_BLK - 1));
  assign blk_clean    = !dirty_q && page_ok;
  assign out_of_tries = (pulses_q >= TRY_W'(MAX_ERASE_TRIES));
  assign retry        = in_verify && scan_last && !blk_clean && !out_of_tries;

  assign tmr_load = accept || retry;
  assign tmr_val  = accept ? wait_for(cmd_op) : TMR_W'(T_ERASE - 1);
  assign ers_en   = (state_q == ST_PULSE) && tmr_zero;
  assign ers_blk  = blk_q;
  assign prg_en   = (state_q == ST_PROG) && tmr_zero;
  assign prg_idx  = IDX_W'(flat_page(int'(blk_q), int'(page_q), PAGES_PER_BLK));
  assign prg_data = data_q;
  assign rd_idx   = in_verify ? IDX_W'(flat_page(int'(blk_q), int'(scan_q), PAGES_PER_BLK))
                              : prg_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      page_q   <= '0;
      data_q   <= '0;
      scan_q   <= '0;
      dirty_q  <= 1'b0;
      pulses_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          blk_q  <= cmd_blk;
          page_q <= cmd_page;
          data_q <= cmd_wdata;
          fail_q <= 1'b0;
          case (cmd_op)
            OP_READ: state_q <= ST_READ;
            OP_PROG: state_q <= ST_PROG;
            default: begin
              state_q  <= ST_PULSE;
              pulses_q <= '0;
            end
          endcase
        end
        ST_READ: if (tmr_zero) begin
          rd_q    <= rd_page;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_PROG: if (tmr_zero) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_PULSE: if (tmr_zero) begin
          pulses_q <= pulses_q + 1'b1;
          scan_q   <= '0;
          dirty_q  <= 1'b0;
          state_q  <= ST_VERIFY;
        end
        ST_VERIFY: begin
          if (!page_ok) dirty_q <= 1'b1;
          if (!scan_last) begin
            scan_q <= scan_q + 1'b1;
          end else if (blk_clean) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (out_of_tries) begin
            fail_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PULSE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign erase_fail   = fail_q;
  assign erase_pulses = pulses_q;
  assign rd_data      = rd_q;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES      = 2,
  parameter int PAGES_PER_BLK   = 64,
  parameter int NUM_BLKS        = 2,
  parameter int CNT_W           = 4,
  parameter int T_READ          = 4,
  parameter int T_PROG          = 10,
  parameter int T_ERASE         = 40,
  parameter int MAX_ERASE_TRIES = 8,
  localparam int PAGE_BITS      = PAGE_BYTES * 8,
  localparam int TOTAL_PAGES    = NUM_BLKS * PAGES_PER_BLK,
  localparam int IDX_W          = (TOTAL_PAGES > 1) ? $clog2(TOTAL_PAGES) : 1,
  localparam int BLK_W          = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int PG_W           = (PAGES_PER_BLK > 1) ? $clog2(PAGES_PER_BLK) : 1,
  localparam int TRY_W          = $clog2(MAX_ERASE_TRIES + 1),
  localparam int TMR_W          = $clog2(T_ERASE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BLK_W-1:0]     cmd_blk,
  input  logic [PG_W-1:0]      cmd_page,
  input  logic [PAGE_BITS-1:0] cmd_wdata,
  input  logic                 hard_we,
  input  logic [BLK_W-1:0]     hard_blk,
  input  logic [PG_W-1:0]      hard_page,
  input  logic [PAGE_BITS-1:0] hard_mask,
  input  logic [CNT_W-1:0]     hard_cnt,
  output logic                 busy,
  output logic                 done,
  output logic                 erase_fail,
  output logic [TRY_W-1:0]     erase_pulses,
  output logic [PAGE_BITS-1:0] rd_data
);
  // R10: the timing order read < program < erase is a hard rule.
  if (!(T_READ > 0 && T_READ < T_PROG && T_PROG < T_ERASE)) begin : g_bad_timing
    $error("delay parameters must satisfy 0 < T_READ < T_PROG < T_ERASE");
  end

  logic                 tmr_load_w, tmr_zero_w;
  logic [TMR_W-1:0]     tmr_val_w;
  logic                 ers_en_w, prg_en_w, accept_w, in_verify_w;
  logic [BLK_W-1:0]     ers_blk_w;
  logic [IDX_W-1:0]     prg_idx_w, rd_idx_w, hard_idx_w;
  logic [PAGE_BITS-1:0] prg_data_w, rd_page_w;

  assign hard_idx_w = IDX_W'(flat_page(int'(hard_blk), int'(hard_page), PAGES_PER_BLK));

  flash_delay_timer #(.W(TMR_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load_w),
    .load_val (tmr_val_w),
    .zero     (tmr_zero_w)
  );

  flash_cell_array #(
    .PAGE_BITS     (PAGE_BITS),
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .NUM_BLKS      (NUM_BLKS),
    .CNT_W         (CNT_W)
  ) array_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ers_en    (ers_en_w),
    .ers_blk   (ers_blk_w),
    .prg_en    (prg_en_w),
    .prg_idx   (prg_idx_w),
    .prg_data  (prg_data_w),
    .hard_we   (hard_we),
    .hard_idx  (hard_idx_w),
    .hard_mask (hard_mask),
    .hard_cnt  (hard_cnt),
    .rd_idx    (rd_idx_w),
    .rd_page   (rd_page_w)
  );

  flash_seq_ctrl #(
    .PAGE_BITS       (PAGE_BITS),
    .PAGES_PER_BLK   (PAGES_PER_BLK),
    .NUM_BLKS        (NUM_BLKS),
    .T_READ          (T_READ),
    .T_PROG          (T_PROG),
    .T_ERASE         (T_ERASE),
    .MAX_ERASE_TRIES (MAX_ERASE_TRIES)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_blk      (cmd_blk),
    .cmd_page     (cmd_page),
    .cmd_wdata    (cmd_wdata),
    .tmr_zero     (tmr_zero_w),
    .rd_page      (rd_page_w),
    .tmr_load     (tmr_load_w),
    .tmr_val      (tmr_val_w),
    .ers_en       (ers_en_w),
    .ers_blk      (ers_blk_w),
    .prg_en       (prg_en_w),
    .prg_idx      (prg_idx_w),
    .prg_data     (prg_data_w),
    .rd_idx       (rd_idx_w),
    .accept       (accept_w),
    .in_verify    (in_verify_w),
    .busy         (busy),
    .done         (done),
    .erase_fail   (erase_fail),
    .erase_pulses (erase_pulses),
    .rd_data      (rd_data)
  );
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int PAGES_PER_BLK   = 64,
  parameter int MAX_ERASE_TRIES = 8,
  localparam int TRY_W          = $clog2(MAX_ERASE_TRIES + 1),
  localparam int VC_W           = $clog2(PAGES_PER_BLK + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic             done,
  input logic             erase_fail,
  input logic [TRY_W-1:0] erase_pulses,
  input logic             accept,
  input logic             ers_pulse,
  input logic             in_verify
);
  logic [VC_W-1:0] vcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vcnt_q <= '0;
    else if (in_verify) vcnt_q <= vcnt_q + 1'b1;
    else                vcnt_q <= '0;
  end

  assert_busy_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'd0) |=> busy);

  assert_nop_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!cmd_valid || cmd_op == 2'd0)) |=> !busy);

  assert_busy_blocks_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  assert_verify_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_verify) |-> (vcnt_q == VC_W'(PAGES_PER_BLK)));

  assert_pulse_count_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ers_pulse && !accept) |=> $stable(erase_pulses));

  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulses <= TRY_W'(MAX_ERASE_TRIES));

  assert_fail_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_fail) |-> (done && erase_pulses == TRY_W'(MAX_ERASE_TRIES)));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .PAGES_PER_BLK   (PAGES_PER_BLK),
  .MAX_ERASE_TRIES (MAX_ERASE_TRIES)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .busy         (busy),
  .done         (done),
  .erase_fail   (erase_fail),
  .erase_pulses (erase_pulses),
  .accept       (accept_w),
  .ers_pulse    (ers_en_w),
  .in_verify    (in_verify_w)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  localparam int TR = 4, TP = 10, TE = 40, PPB = 64, MAXP = 8;
  localparam int ITER = TE + PPB;

  typedef struct packed {
    logic [1:0]  op;
    logic [0:0]  blk;
    logic [5:0]  page;
    logic [15:0] wdata;
    logic [15:0] exp_rd;
    logic [15:0] lat;
    logic [3:0]  pulses;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 6'd3,  16'h0000, 16'hFFFF, 16'(TR),   4'd0},
    '{2'd2, 1'b0, 6'd3,  16'hA5F0, 16'h0000, 16'(TP),   4'd0},
    '{2'd1, 1'b0, 6'd3,  16'h0000, 16'hA5F0, 16'(TR),   4'd0},
    '{2'd2, 1'b0, 6'd3,  16'h0FFF, 16'h0000, 16'(TP),   4'd0},
    '{2'd1, 1'b0, 6'd3,  16'h0000, 16'h05F0, 16'(TR),   4'd0},
    '{2'd2, 1'b1, 6'd5,  16'h1234, 16'h0000, 16'(TP),   4'd0},
    '{2'd2, 1'b0, 6'd63, 16'h00FF, 16'h0000, 16'(TP),   4'd0},
    '{2'd3, 1'b0, 6'd0,  16'h0000, 16'h0000, 16'(ITER), 4'd1},
    '{2'd1, 1'b0, 6'd3,  16'h0000, 16'hFFFF, 16'(TR),   4'd0},
    '{2'd1, 1'b0, 6'd63, 16'h0000, 16'hFFFF, 16'(TR),   4'd0},
    '{2'd1, 1'b1, 6'd5,  16'h0000, 16'h1234, 16'(TR),   4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [0:0]  cmd_blk = '0;
  logic [5:0]  cmd_page = '0;
  logic [15:0] cmd_wdata = '0;
  logic        hard_we = 1'b0;
  logic [0:0]  hard_blk = '0;
  logic [5:0]  hard_page = '0;
  logic [15:0] hard_mask = '0;
  logic [3:0]  hard_cnt = '0;
  logic        busy, done, erase_fail;
  logic [3:0]  erase_pulses;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .PAGE_BYTES(2), .PAGES_PER_BLK(PPB), .NUM_BLKS(2), .CNT_W(4),
    .T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .MAX_ERASE_TRIES(MAXP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_wdata(cmd_wdata),
    .hard_we(hard_we), .hard_blk(hard_blk), .hard_page(hard_page),
    .hard_mask(hard_mask), .hard_cnt(hard_cnt), .busy(busy), .done(done),
    .erase_fail(erase_fail), .erase_pulses(erase_pulses), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_up();
    end
  end

  // Issues one command and counts the falling edges with busy high.
  task automatic issue(input logic [1:0] op, input logic b, input logic [5:0] pg,
                       input logic [15:0] wd, output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = b; cmd_page = pg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    lat = 0;
    while (busy && lat < 5000) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic mark_hard(input logic b, input logic [5:0] pg,
                           input logic [15:0] m, input logic [3:0] c);
    @(negedge clk);
    hard_we = 1'b1; hard_blk = b; hard_page = pg; hard_mask = m; hard_cnt = c;
    @(negedge clk);
    hard_we = 1'b0;
  endtask

  task automatic do_read(input logic b, input logic [5:0] pg,
                         input logic [15:0] exp, input string req);
    int lat;
    issue(2'd1, b, pg, 16'h0, lat);
    chk(lat == TR, "R4", "read latency", lat, TR);
    chk(rd_data == exp, req, "read data", rd_data, exp);
  endtask

  task automatic do_erase(input logic b, input int exp_p, input bit exp_f,
                          input string req);
    int lat;
    issue(2'd3, b, 6'd0, 16'h0, lat);
    chk(lat == exp_p * ITER, "R6", "erase latency", lat, exp_p * ITER);
    chk(erase_pulses == 4'(exp_p), req, "pulse count", erase_pulses, exp_p);
    chk(erase_fail == exp_f, "R9", "erase_fail", erase_fail, exp_f);
    chk(done == 1'b1, "R11", "done at end", done, 1);
  endtask

  initial begin
    int lat;
    int lat_r, lat_p, lat_e;
    lat_r = 0; lat_p = 0; lat_e = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!erase_fail && erase_pulses == 0, "R1", "status after reset",
        {erase_fail, erase_pulses}, 0);
    chk(rd_data == 16'h0, "R1", "rd_data after reset", rd_data, 0);

    // R2 op code 0 is not a command
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy, "R2", "busy after no-op", busy, 0);

    // Table walk: R4, R5, R7 main function
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].blk[0], VEC[i].page, VEC[i].wdata, lat);
      chk(lat == int'(VEC[i].lat), "R2", $sformatf("vector %0d latency", i),
          lat, VEC[i].lat);
      chk(done, "R11", $sformatf("vector %0d done", i), done, 1);
      if (VEC[i].op == 2'd1) begin
        chk(rd_data == VEC[i].exp_rd, "R5", $sformatf("vector %0d page data", i),
            rd_data, VEC[i].exp_rd);
        lat_r = lat;
      end
      if (VEC[i].op == 2'd2) lat_p = lat;
      if (VEC[i].op == 2'd3) begin
        chk(erase_pulses == VEC[i].pulses, "R7", $sformatf("vector %0d pulses", i),
            erase_pulses, VEC[i].pulses);
        lat_e = lat;
      end
      @(negedge clk);
      chk(!done, "R11", $sformatf("vector %0d done width", i), done, 0);
    end
    // R1 untouched page of a never-erased area reads all ones
    do_read(1'b1, 6'd7, 16'hFFFF, "R1");
    // R10 ordering shows in the measured delays
    chk(lat_r < lat_p && lat_p < lat_e, "R10", "read<prog<erase", lat_p, lat_e);

    // R3 commands during busy are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_blk = 1'b1; cmd_page = 6'd5;
    @(negedge clk);
    cmd_op = 2'd2; cmd_wdata = 16'h0000;
    lat = 0;
    while (busy && lat < 5000) begin
      lat++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_op = 2'd0;
    chk(lat == TR, "R3", "read latency with traffic", lat, TR);
    chk(rd_data == 16'h1234, "R3", "read data with traffic", rd_data, 16'h1234);
    do_read(1'b1, 6'd5, 16'h1234, "R3");

    // R8 hard cells and R7 retries, first and last page of a block
    mark_hard(1'b1, 6'd5, 16'h0010, 4'd3);
    do_read(1'b1, 6'd5, 16'h1224, "R8");
    mark_hard(1'b1, 6'd0, 16'h8000, 4'd2);
    mark_hard(1'b1, 6'd63, 16'h0001, 4'd5);
    do_erase(1'b1, 5, 1'b0, "R7");
    do_read(1'b1, 6'd5, 16'hFFFF, "R7");
    do_read(1'b1, 6'd0, 16'hFFFF, "R8");
    do_read(1'b1, 6'd63, 16'hFFFF, "R8");

    // R8 need of zero still takes one pulse
    mark_hard(1'b0, 6'd0, 16'hFFFF, 4'd0);
    do_read(1'b0, 6'd0, 16'h0000, "R8");
    do_erase(1'b0, 1, 1'b0, "R8");

    // R9 running out of pulses
    mark_hard(1'b0, 6'd63, 16'h0001, 4'd12);
    do_erase(1'b0, MAXP, 1'b1, "R9");
    repeat (3) @(negedge clk);
    chk(erase_fail, "R9", "fail held while idle", erase_fail, 1);
    do_read(1'b0, 6'd63, 16'hFFFE, "R9");
    chk(!erase_fail, "R9", "fail cleared by next command", erase_fail, 0);
    do_erase(1'b0, 4, 1'b0, "R9");
    do_read(1'b0, 6'd63, 16'hFFFF, "R9");

    finish_up();
  end
endmodule